// File: doc/BRIEF.md
# Configurable UART Frame Engine

A full-duplex asynchronous serial transmitter and receiver whose frame shape is set at run time. Software-facing logic elsewhere supplies a one-cycle oversampling tick at sixteen times the bit rate. It also writes the frame options through a single write strobe: data width of 7 or 8 bits, most- or least-significant-bit first, a parity mode, and the number of transmit stop bits.

Bytes to send enter through a valid/ready handshake and leave on `txd`. Serial data on `rxd` is synchronised, located by its falling start edge, and sampled at the middle of each bit. The recovered byte is then presented with a valid strobe that stays up until it is acknowledged. Parity, framing and overrun errors are flagged alongside the byte. Each direction has its own enable. A configuration write is taken only for the fields whose direction (or both directions) is disabled at that moment.

Top module: `uart_frame_engine`

## Requirements
- R1: With `cfg_len8`=1 frames carry 8 data bits and with 0 they carry 7, in both directions. A 7-bit received byte appears with `rx_data[7]`=0.
- R2: `cfg_msb_first`=1 sends and expects the highest data bit first, and 0 sends and expects bit 0 first. The same order applies in both directions.
- R3: `cfg_par` selects the transmit parity bit, which follows the last data bit. 00 sends no parity bit. 01 sends a 0. 10 sends a bit that makes the count of ones in data plus parity odd. 11 makes that count even.
- R4: The receiver uses the same `cfg_par` codes. 00 expects no parity bit. 01 takes a parity bit but never raises `rx_parity_err`. 10 and 11 raise `rx_parity_err` with the byte when the received count of ones is not odd (10) or not even (11).
- R5: `cfg_stop2`=1 makes the transmitter send two stop bits (line high), and 0 sends one. `tx_ready` stays low until the last stop bit has ended.
- R6: The receiver samples exactly one stop bit whatever `cfg_stop2` says, so a new start bit may follow it at once. A 0 in that position raises `rx_frame_err`, and the byte is still delivered with `rx_valid`.
- R7: A byte that completes while `rx_valid` is high and `rx_read` is low is discarded, `rx_overrun` goes high, and the held byte is kept.
- R8: On `cfg_wr` the width, order and parity fields are taken only when `tx_en` and `rx_en` are both low. The stop field is taken only when `tx_en` is low. The remaining fields of such a write are ignored.
- R9: `tx_ready` is high exactly when `tx_en` is high and no frame is in flight. `txd` idles high, and a frame starts with a low start bit on the cycle after a handshake.
- R10: `rx_valid` stays high until `rx_read` is pulsed. `rx_read` clears `rx_valid` and all three error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling strobe, 16 per bit period |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_msb_first | input | 1 | 1: highest bit first, 0: bit 0 first |
| cfg_par | input | 2 | Parity mode: 00 none, 01 zero, 10 odd, 11 even |
| cfg_stop2 | input | 1 | Transmit stop bits: 1 means two |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte held |
| rx_read | input | 1 | Acknowledge of the held byte |
| rx_parity_err | output | 1 | Parity mismatch on held byte |
| rx_frame_err | output | 1 | Stop bit sampled low on held byte |
| rx_overrun | output | 1 | A later byte was lost |

## Verification
The assertions take for granted that `tick` is a single-cycle pulse and that `rx_read` is raised only while a byte is held. They also assume that the `rxd` waveform keeps each bit for sixteen ticks, so the mid-bit sample lands inside the bit. The bench generates `tick` as a one-cycle strobe every fourth clock. It drives `rxd` with frames built at exactly 64 clocks per bit, and it pulses `rx_read` only after it has seen `rx_valid` high. Configuration is written only while both enables are in a known state, so the frozen-field properties are exercised both by taken and by ignored writes.

// File: rtl/uart_frame_engine.sv
module uart_frame_engine #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic       cfg_wr,
  input  logic       cfg_len8,
  input  logic       cfg_msb_first,
  input  logic [1:0] cfg_par,
  input  logic       cfg_stop2,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       txd,
  input  logic       rxd,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_read,
  output logic       rx_parity_err,
  output logic       rx_frame_err,
  output logic       rx_overrun
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic       len8_q, msb_q, stop2_q;
  logic [1:0] par_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      len8_q <= 1'b1; msb_q <= 1'b0; par_q <= 2'b00; stop2_q <= 1'b0;
    end else if (cfg_wr) begin
      if (!tx_en && !rx_en) begin
        len8_q <= cfg_len8; msb_q <= cfg_msb_first; par_q <= cfg_par;
      end
      if (!tx_en) stop2_q <= cfg_stop2;
    end

  logic [3:0] nbits, par_idx, stop_idx, tx_last;
  logic       par_on;
  logic [7:0] mask;
  assign nbits    = len8_q ? 4'd8 : 4'd7;
  assign par_on   = |par_q;
  assign mask     = {len8_q, 7'h7f};
  assign par_idx  = nbits + 4'd1;
  assign stop_idx = nbits + 4'd1 + {3'b0, par_on};
  assign tx_last  = stop_idx + {3'b0, stop2_q};

  // transmitter
  logic          tx_busy, tx_bit, tx_dp;
  logic [7:0]    tx_sh;
  logic [CW-1:0] tx_tc;
  logic [3:0]    tx_idx, tx_pos;

  assign tx_dp  = ^(tx_sh & mask);
  assign tx_pos = msb_q ? (nbits - tx_idx) : (tx_idx - 4'd1);

  always_comb begin
    if (tx_idx == 4'd0)                     tx_bit = 1'b0;
    else if (tx_idx <= nbits)               tx_bit = tx_sh[tx_pos[2:0]];
    else if (par_on && tx_idx == par_idx)   tx_bit = (par_q == 2'b01) ? 1'b0 :
                                                     (par_q == 2'b10) ? ~tx_dp : tx_dp;
    else                                    tx_bit = 1'b1;
  end

  assign txd      = tx_busy ? tx_bit : 1'b1;
  assign tx_ready = tx_en & ~tx_busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_sh <= '0; tx_tc <= '0; tx_idx <= '0;
    end else if (!tx_en) begin
      tx_busy <= 1'b0;
    end else if (!tx_busy) begin
      if (tx_valid) begin
        tx_busy <= 1'b1; tx_sh <= tx_data; tx_tc <= '0; tx_idx <= '0;
      end
    end else if (tick) begin
      if (tx_tc == LAST) begin
        tx_tc <= '0;
        if (tx_idx == tx_last) tx_busy <= 1'b0;
        else                   tx_idx  <= tx_idx + 4'd1;
      end else begin
        tx_tc <= tx_tc + 1'b1;
      end
    end

  // receiver
  logic          r1, r2, armed, rx_busy, rx_pbit, rx_dp, samp, rx_start, rx_done;
  logic [7:0]    rx_sh;
  logic [CW-1:0] rx_tc;
  logic [3:0]    rx_idx, rx_pos;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin r1 <= 1'b1; r2 <= 1'b1; end
    else        begin r1 <= rxd;  r2 <= r1;   end

  assign samp     = rx_en & tick & rx_busy & (rx_tc == MID);
  assign rx_start = rx_en & tick & ~rx_busy & armed & ~r2;
  assign rx_done  = samp & (rx_idx == stop_idx);
  assign rx_pos   = msb_q ? (nbits - rx_idx) : (rx_idx - 4'd1);
  assign rx_dp    = ^(rx_sh & mask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        armed <= 1'b0;
    else if (rx_start) armed <= 1'b0;
    else if (rx_done)  armed <= r2;
    else if (r2)       armed <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0; rx_tc <= '0; rx_idx <= '0; rx_sh <= '0; rx_pbit <= 1'b0;
    end else if (!rx_en) begin
      rx_busy <= 1'b0;
    end else if (rx_start) begin
      rx_busy <= 1'b1; rx_tc <= '0; rx_idx <= '0; rx_sh <= '0;
    end else if (rx_busy && tick) begin
      rx_tc <= (rx_tc == LAST) ? '0 : rx_tc + 1'b1;
      if (rx_tc == MID) begin
        if (rx_idx == 4'd0) begin
          if (r2) rx_busy <= 1'b0;
          else    rx_idx  <= 4'd1;
        end else if (rx_idx <= nbits) begin
          rx_sh[rx_pos[2:0]] <= r2;
          rx_idx <= rx_idx + 4'd1;
        end else if (par_on && rx_idx == par_idx) begin
          rx_pbit <= r2;
          rx_idx  <= rx_idx + 4'd1;
        end else begin
          rx_busy <= 1'b0;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data <= '0; rx_valid <= 1'b0;
      rx_parity_err <= 1'b0; rx_frame_err <= 1'b0; rx_overrun <= 1'b0;
    end else begin
      if (rx_read) begin
        rx_valid <= 1'b0; rx_parity_err <= 1'b0;
        rx_frame_err <= 1'b0; rx_overrun <= 1'b0;
      end
      if (rx_done) begin
        if (rx_valid && !rx_read) begin
          rx_overrun <= 1'b1;
        end else begin
          rx_data       <= rx_sh;
          rx_valid      <= 1'b1;
          rx_frame_err  <= ~r2;
          rx_parity_err <= (par_q == 2'b10) ? ~(rx_dp ^ rx_pbit) :
                           (par_q == 2'b11) ?  (rx_dp ^ rx_pbit) : 1'b0;
        end
      end
    end
endmodule

// File: rtl/uart_frame_engine_chk.sv
module uart_frame_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       rx_en,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_read,
  input logic       rx_parity_err,
  input logic       rx_overrun,
  input logic       len8_q,
  input logic       msb_q,
  input logic [1:0] par_q,
  input logic       stop2_q
);
  AST_READY_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> txd); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) tx_valid && tx_ready |=> !tx_ready); // R9
  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n) rx_valid && !rx_read |=> rx_valid); // R10
  AST_READ_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n) rx_read |=> !rx_overrun); // R7
  AST_OVR_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n) rx_overrun |-> rx_valid); // R7
  AST_PERR_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n) rx_parity_err |-> rx_valid); // R4
  AST_ZERO_PAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_valid) && par_q == 2'b01 |-> !rx_parity_err); // R4
  AST_SEVEN_BIT_TOP: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_valid) && !len8_q |-> !rx_data[7]); // R1
  AST_SHAPE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (tx_en || rx_en) |=> $stable(len8_q) && $stable(msb_q) && $stable(par_q)); // R8
  AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) tx_en |=> $stable(stop2_q)); // R8
endmodule

bind uart_frame_engine uart_frame_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
  .rx_data(rx_data), .rx_valid(rx_valid), .rx_read(rx_read),
  .rx_parity_err(rx_parity_err), .rx_overrun(rx_overrun),
  .len8_q(len8_q), .msb_q(msb_q), .par_q(par_q), .stop2_q(stop2_q)
);

// File: tb/uart_frame_engine_tb.sv
module uart_frame_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick;
  logic tx_en = 0, rx_en = 0, cfg_wr = 0, cfg_len8 = 1, cfg_msb_first = 0, cfg_stop2 = 0;
  logic [1:0] cfg_par = 0;
  logic [7:0] tx_data = 0, rx_data;
  logic tx_valid = 0, tx_ready, txd, rxd = 1, rx_valid, rx_read = 0;
  logic rx_parity_err, rx_frame_err, rx_overrun;
  logic [1:0] tdiv = 0;
  int checks = 0, fails = 0;
  logic m_len8 = 1, m_msb = 0, m_st2 = 0;
  logic [1:0] m_par = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);

  uart_frame_engine u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int build(input logic [7:0] d, input logic l8, input logic msb,
                               input logic [1:0] par, input logic st2, output logic [11:0] f);
    int n = l8 ? 8 : 7;
    int k = 1;
    int ones = 0;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      f[k] = msb ? d[n-1-i] : d[i];
      ones += d[i];
      k++;
    end
    if (par != 2'b00) begin
      f[k] = (par == 2'b01) ? 1'b0 : (par == 2'b10) ? ~ones[0] : ones[0];
      k++;
    end
    k += st2 ? 2 : 1;
    return k;
  endfunction

  task automatic set_cfg(input logic l8, input logic msb, input logic [1:0] par, input logic st2);
    @(negedge clk);
    cfg_wr = 1; cfg_len8 = l8; cfg_msb_first = msb; cfg_par = par; cfg_stop2 = st2;
    if (!tx_en && !rx_en) begin m_len8 = l8; m_msb = msb; m_par = par; end
    if (!tx_en) m_st2 = st2;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic tx_case(input logic [7:0] d, input string tag);
    logic [11:0] f, got;
    int k = build(d, m_len8, m_msb, m_par, m_st2, f);
    got = '1;
    @(negedge clk);
    chk(tx_ready === 1'b1, {tag, " R9 ready before send"}, tx_ready, 1);
    tx_data = d; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    repeat (31) @(negedge clk);
    for (int i = 0; i < k; i++) begin
      if (i > 0) repeat (64) @(negedge clk);
      got[i] = txd;
    end
    chk(got === f, {tag, " frame"}, got, f);
    chk(tx_ready === 1'b0, {tag, " R5 busy in last stop"}, tx_ready, 0);
    repeat (64) @(negedge clk);
    chk(tx_ready === 1'b1 && txd === 1'b1, {tag, " R5 R9 done and idle"}, {tx_ready, txd}, 2'b11);
  endtask

  task automatic rx_drive(input logic [11:0] f, input int k, input bit trail);
    for (int i = 0; i < k; i++) begin
      @(negedge clk) rxd = f[i];
      repeat (63) @(negedge clk);
    end
    @(negedge clk) rxd = 1'b1;
    if (trail) repeat (64) @(negedge clk);
  endtask

  task automatic rx_read_pulse();
    @(negedge clk) rx_read = 1;
    @(negedge clk) rx_read = 0;
  endtask

  task automatic rx_expect(input logic [7:0] d, input logic pe, input logic fe, input logic ov, input string tag);
    logic [7:0] ed = m_len8 ? d : {1'b0, d[6:0]};
    chk(rx_valid === 1'b1, {tag, " R10 valid"}, rx_valid, 1);
    chk(rx_data === ed, {tag, " R1 R2 data"}, rx_data, ed);
    chk({rx_parity_err, rx_frame_err, rx_overrun} === {pe, fe, ov}, {tag, " R4 R6 R7 flags"},
        {rx_parity_err, rx_frame_err, rx_overrun}, {pe, fe, ov});
  endtask

  task automatic rx_case(input logic [7:0] d, input bit flip_par, input bit zero_stop, input string tag);
    logic [11:0] f;
    int k = build(d, m_len8, m_msb, m_par, 1'b0, f);
    logic pe = flip_par && (m_par == 2'b10 || m_par == 2'b11);
    if (flip_par) f[m_len8 ? 9 : 8] ^= 1'b1;
    if (zero_stop) f[k-1] = 1'b0;
    rx_drive(f, k, 1);
    rx_expect(d, pe, zero_stop, 1'b0, tag);
    rx_read_pulse();
    chk({rx_valid, rx_parity_err, rx_frame_err, rx_overrun} === 4'b0, {tag, " R10 read clears"},
        {rx_valid, rx_parity_err, rx_frame_err, rx_overrun}, 0);
  endtask

  task automatic rx_back_to_back(input logic [7:0] a, input logic [7:0] b);
    logic [11:0] fa, fb;
    int ka = build(a, m_len8, m_msb, m_par, 1'b0, fa);
    int kb = build(b, m_len8, m_msb, m_par, 1'b0, fb);
    rx_drive(fa, ka, 0);
    fork
      rx_drive(fb, kb, 1);
      begin
        repeat (8) @(negedge clk);
        rx_expect(a, 0, 0, 0, "R6 first of pair");
        rx_read_pulse();
      end
    join
    rx_expect(b, 0, 0, 0, "R6 second of pair, single stop");
    rx_read_pulse();
  endtask

  task automatic rx_overrun_case(input logic [7:0] a, input logic [7:0] b);
    logic [11:0] fa, fb;
    int ka = build(a, m_len8, m_msb, m_par, 1'b0, fa);
    int kb = build(b, m_len8, m_msb, m_par, 1'b0, fb);
    rx_drive(fa, ka, 1);
    rx_drive(fb, kb, 1);
    rx_expect(a, 0, 0, 1, "R7 overrun keeps old byte");
    rx_read_pulse();
    chk({rx_valid, rx_overrun} === 2'b00, "R7 R10 read clears overrun", {rx_valid, rx_overrun}, 0);
  endtask

  task automatic test_reset();
    chk(txd === 1'b1 && tx_ready === 1'b0, "R9 reset line and ready", {txd, tx_ready}, 2'b10);
    chk({rx_valid, rx_parity_err, rx_frame_err, rx_overrun} === 4'b0, "R10 reset rx state",
        {rx_valid, rx_parity_err, rx_frame_err, rx_overrun}, 0);
  endtask

  task automatic test_basic();
    set_cfg(1, 0, 2'b00, 0);
    tx_en = 1; rx_en = 1;
    tx_case(8'hA5, "R1 R2 8N1 lsb");
    rx_case(8'h3C, 0, 0, "R1 R2 rx 8N1 lsb");
  endtask

  task automatic test_seven_msb_even();
    tx_en = 0; rx_en = 0;
    set_cfg(0, 1, 2'b11, 1);
    tx_en = 1; rx_en = 1;
    tx_case(8'hD3, "R1 R2 R3 R5 7E2 msb");
    rx_case(8'hC9, 0, 0, "R1 R2 rx 7-bit zero top");
    rx_case(8'h35, 1, 0, "R4 even mismatch");
  endtask

  task automatic test_odd();
    tx_en = 0; rx_en = 0;
    set_cfg(1, 0, 2'b10, 0);
    tx_en = 1; rx_en = 1;
    tx_case(8'h01, "R3 odd");
    tx_case(8'h03, "R3 odd even-weight");
    rx_case(8'h81, 0, 0, "R4 odd good");
    rx_case(8'h81, 1, 0, "R4 odd mismatch");
  endtask

  task automatic test_zero_par();
    tx_en = 0; rx_en = 0;
    set_cfg(1, 1, 2'b01, 0);
    tx_en = 1; rx_en = 1;
    tx_case(8'hFF, "R3 zero parity");
    rx_case(8'h6E, 1, 0, "R4 zero parity never flags");
  endtask

  task automatic test_rx_stop();
    tx_en = 0; rx_en = 0;
    set_cfg(1, 0, 2'b00, 1);
    rx_en = 1;
    rx_back_to_back(8'h5A, 8'hC3);
    rx_case(8'h77, 0, 1, "R6 framing error");
    rx_overrun_case(8'h12, 8'h34);
  endtask

  task automatic test_gating();
    tx_en = 1; rx_en = 0;
    set_cfg(0, 1, 2'b10, 0);
    tx_case(8'h96, "R8 all fields ignored while tx on");
    tx_en = 0; rx_en = 1;
    set_cfg(0, 1, 2'b10, 0);
    tx_en = 1;
    tx_case(8'h96, "R8 only stop taken while rx on");
    chk(m_st2 === 1'b0 && m_len8 === 1'b1, "R8 expected mirror", {m_st2, m_len8}, 2'b01);
  endtask

  initial begin
    bit timed_out = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    fork
      begin
        test_reset();
        test_basic();
        test_seven_msb_even();
        test_odd();
        test_zero_par();
        test_rx_stop();
        test_gating();
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule